// File: doc/BRIEF.md
# Pixel Region Hit Buffer

This block collects binary hits from several regions of a monolithic pixel sensor during a bunch train and returns them after the train ends. Each region is one logic column. It serves 42 comparator outputs, arranged as seven groups of six pixels, and each pixel has its own mask bit. When a bunch pulse arrives while a train is open, the block samples the unmasked hits of every region. It keeps one pending pattern per group and writes one record for each group that hit, in ascending group order, at one record per clock. Each record is tagged with the 13-bit bunch timestamp of its bunch and is stored in a small per-column memory.

Capture ends on a stop request or after the bunch whose timestamp is the largest value. The block then finishes writing the pending groups and drains the columns in order through a 30-bit valid/ready port. An end-of-data word follows the last record. When that word is accepted, every column buffer and every overflow flag is cleared for the next train. If a column's memory is full, its further records are discarded and a sticky overflow bit is set. That bit appears in every word read from the column.

Top module: `pixreg_hitbuf`

## Requirements
- R1: A pixel whose mask bit is 1 never contributes to a record, and a group whose hits are all masked writes no record.
- R2: On each accepted bunch pulse, every group that has at least one unmasked hit yields exactly one record. Its 6-bit pattern has bit i set when pixel group*6+i of that column hit and is unmasked. Pixel p of column c is hit_i[c*42+p].
- R3: Word layout: bit 29 is the end marker, bit 28 is the column overflow flag, bits 27:22 are the column index, bits 21:9 are the timestamp, bits 8:6 are the group index and bits 5:0 are the pattern.
- R4: Records of one column are read out in capture order. Within one bunch, the records are in ascending group order.
- R5: The first bunch after train_start is tagged 0, and each later accepted bunch is tagged one higher. capture_active is 1 from the cycle after train_start until capture ends.
- R6: Capture ends on train_stop or after the bunch tagged 8191. Bunch pulses after that point produce no records.
- R7: A column keeps at most DEPTH records per train. Further records are discarded, and bit 28 is 1 in every word read from that column and in the end-of-data word.
- R8: Readout starts only after capture has ended. Columns are sent in order 0 to NCOL-1. While rd_valid is high and rd_ready is low, rd_data holds steady.
- R9: After the last column, one end-of-data word {1, OR of column overflow flags, 28 zeros} is sent. Once it is accepted, rd_valid drops and the next train starts from empty buffers with overflow cleared.
- R10: train_start has no effect while a train is being captured or drained.
- R11: After reset, rd_valid and capture_active are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start | input | 1 | Opens a train when the block is idle |
| train_stop | input | 1 | Closes capture of the current train |
| bunch_tick | input | 1 | One pulse per bunch; samples hits, at least 7 clocks apart |
| hit_i | input | NCOL*42 | Comparator outputs of all columns |
| mask_i | input | NCOL*42 | Per-pixel mask, 1 = ignored |
| rd_ready | input | 1 | Readout sink accepts the current word |
| capture_active | output | 1 | Train capture in progress |
| rd_valid | output | 1 | rd_data holds a word |
| rd_data | output | 30 | Record or end-of-data word |

## Verification
The bench checks several cases:
- It masks one pixel of a group that hit and masks all of another group. A design that applied the mask after encoding would emit empty or wrong patterns.
- It fires many groups in one bunch. A wrong priority encoder would mix up the group order or skip groups.
- It overfills one column. This catches a count that wraps and overwrites records, and a flag that fails to reach the data words or the end-of-data word.
- It runs one train through all 8192 timestamps and keeps sending bunches afterwards. This exposes a counter that wraps silently back to 0.
- It throttles rd_ready at random and pulses train_start during the drain. These catch data that moves while stalled and a drain that a new train corrupts.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DRAIN = 2'd3
  } hb_state_e;
endpackage

// File: rtl/pixreg_col.sv
module pixreg_col #(
  parameter int NGRP    = 7,
  parameter int GRP_PIX = 6,
  parameter int TS_W    = 13,
  parameter int DEPTH   = 16,
  localparam int PIX    = NGRP * GRP_PIX,
  localparam int GIDX_W = $clog2(NGRP),
  localparam int REC_W  = TS_W + GIDX_W + GRP_PIX,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              clr,
  input  logic [TS_W-1:0]   ts,
  input  logic [PIX-1:0]    hit,
  input  logic [PIX-1:0]    mask,
  input  logic [AW-1:0]     rd_addr,
  output logic              pend_any,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf,
  output logic [REC_W-1:0]  rd_rec
);
  logic [NGRP-1:0][GRP_PIX-1:0] pend_q, pend_d;
  logic [TS_W-1:0]    pts_q, pts_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ovf_q, ovf_d;
  logic [PIX-1:0]     live;
  logic [GIDX_W-1:0]  pick;
  logic [GRP_PIX-1:0] pick_pat;
  logic               found, room, we;
  logic [REC_W-1:0]   mem_q [DEPTH];

  assign live = hit & ~mask;

  // lowest non-empty pending group wins
  always_comb begin
    found    = 1'b0;
    pick     = '0;
    pick_pat = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (|pend_q[g]) begin
        found    = 1'b1;
        pick     = GIDX_W'(g);
        pick_pat = pend_q[g];
      end
    end
  end

  assign room = (cnt_q < CNT_W'(DEPTH));
  assign we   = found && room;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      if (cap_en)                              pend_d[g] = live[g*GRP_PIX +: GRP_PIX];
      else if (found && pick == GIDX_W'(g))    pend_d[g] = '0;
      else                                     pend_d[g] = pend_q[g];
    end
    pts_d = cap_en ? ts : pts_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (we) begin
      cnt_d = cnt_q + 1'b1;
    end else if (found) begin
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pts_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pts_q  <= pts_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[cnt_q[AW-1:0]] <= {pts_q, pick, pick_pat};
  end

  assign rd_rec   = mem_q[rd_addr];
  assign pend_any = found;
  assign cnt      = cnt_q;
  assign ovf      = ovf_q;
endmodule

// File: rtl/pixreg_ctrl.sv
module pixreg_ctrl
  import pixreg_pkg::*;
#(
  parameter int NCOL  = 4,
  parameter int TS_W  = 13,
  parameter int CNT_W = 5,
  localparam int CS_W = $clog2(NCOL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start,
  input  logic             train_stop,
  input  logic             bunch_tick,
  input  logic             pend_any,
  input  logic [CNT_W-1:0] sel_cnt,
  input  logic             rd_ready,
  output logic             cap_en,
  output logic             clr,
  output logic [TS_W-1:0]  ts,
  output logic [CS_W-1:0]  col_sel,
  output logic [CNT_W-1:0] rd_ptr,
  output logic             capturing,
  output logic             rec_valid,
  output logic             eod_valid
);
  hb_state_e        st_q, st_d;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic [CS_W-1:0]  cs_q, cs_d;
  logic [CNT_W-1:0] rp_q, rp_d;

  always_comb begin
    st_d = st_q; ts_d = ts_q; cs_d = cs_q; rp_d = rp_q;
    cap_en = 1'b0; clr = 1'b0; rec_valid = 1'b0; eod_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: if (train_start) begin
        st_d = ST_CAPT;
        ts_d = '0;
      end
      ST_CAPT: if (train_stop) begin
        st_d = ST_FLUSH;
      end else if (bunch_tick) begin
        cap_en = 1'b1;
        ts_d   = ts_q + 1'b1;
        if (&ts_q) st_d = ST_FLUSH;
      end
      ST_FLUSH: if (!pend_any) begin
        st_d = ST_DRAIN;
        cs_d = '0;
        rp_d = '0;
      end
      ST_DRAIN: begin
        if (cs_q == CS_W'(NCOL)) begin
          eod_valid = 1'b1;
          if (rd_ready) begin
            clr  = 1'b1;
            st_d = ST_IDLE;
          end
        end else if (rp_q < sel_cnt) begin
          rec_valid = 1'b1;
          if (rd_ready) rp_d = rp_q + 1'b1;
        end else begin
          cs_d = cs_q + 1'b1;
          rp_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ts_q <= '0;
      cs_q <= '0;
      rp_q <= '0;
    end else begin
      st_q <= st_d;
      ts_q <= ts_d;
      cs_q <= cs_d;
      rp_q <= rp_d;
    end
  end

  assign ts        = ts_q;
  assign col_sel   = cs_q;
  assign rd_ptr    = rp_q;
  assign capturing = (st_q == ST_CAPT);
endmodule

// File: rtl/pixreg_hitbuf.sv
module pixreg_hitbuf #(
  parameter int NCOL    = 4,
  parameter int NGRP    = 7,
  parameter int GRP_PIX = 6,
  parameter int TS_W    = 13,
  parameter int DEPTH   = 16,
  parameter int COLID_W = 6,
  localparam int PIX    = NGRP * GRP_PIX,
  localparam int GIDX_W = $clog2(NGRP),
  localparam int REC_W  = TS_W + GIDX_W + GRP_PIX,
  localparam int WORD_W = 2 + COLID_W + REC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 train_start,
  input  logic                 train_stop,
  input  logic                 bunch_tick,
  input  logic [NCOL*PIX-1:0]  hit_i,
  input  logic [NCOL*PIX-1:0]  mask_i,
  input  logic                 rd_ready,
  output logic                 capture_active,
  output logic                 rd_valid,
  output logic [WORD_W-1:0]    rd_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AW    = $clog2(DEPTH);
  localparam int CS_W  = $clog2(NCOL + 1);
  localparam int CI_W  = (NCOL > 1) ? $clog2(NCOL) : 1;

  logic              rs_meta, rs_n;
  logic              cap_en, clr, rec_valid, eod_valid, pend_or;
  logic [TS_W-1:0]   ts_q;
  logic [CS_W-1:0]   col_sel;
  logic [CNT_W-1:0]  rd_ptr, sel_cnt;
  logic [CI_W-1:0]   csi;
  logic [NCOL-1:0]   pend_a, ovf_a;
  logic [CNT_W-1:0]  cnt_a [NCOL];
  logic [REC_W-1:0]  rec_a [NCOL];

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    pixreg_col #(
      .NGRP(NGRP), .GRP_PIX(GRP_PIX), .TS_W(TS_W), .DEPTH(DEPTH)
    ) u_col (
      .clk(clk), .rst_n(rs_n), .cap_en(cap_en), .clr(clr), .ts(ts_q),
      .hit(hit_i[c*PIX +: PIX]), .mask(mask_i[c*PIX +: PIX]),
      .rd_addr(rd_ptr[AW-1:0]), .pend_any(pend_a[c]), .cnt(cnt_a[c]),
      .ovf(ovf_a[c]), .rd_rec(rec_a[c])
    );
  end

  assign pend_or = |pend_a;
  assign csi     = (col_sel < CS_W'(NCOL)) ? CI_W'(col_sel) : '0;
  assign sel_cnt = (col_sel < CS_W'(NCOL)) ? cnt_a[csi] : '0;

  pixreg_ctrl #(.NCOL(NCOL), .TS_W(TS_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rs_n), .train_start(train_start), .train_stop(train_stop),
    .bunch_tick(bunch_tick), .pend_any(pend_or), .sel_cnt(sel_cnt),
    .rd_ready(rd_ready), .cap_en(cap_en), .clr(clr), .ts(ts_q),
    .col_sel(col_sel), .rd_ptr(rd_ptr), .capturing(capture_active),
    .rec_valid(rec_valid), .eod_valid(eod_valid)
  );

  assign rd_valid = rec_valid | eod_valid;
  assign rd_data  = eod_valid ? {1'b1, |ovf_a, {(WORD_W-2){1'b0}}}
                              : {1'b0, ovf_a[csi], COLID_W'(csi), rec_a[csi]};
endmodule

// File: rtl/pixreg_chk.sv
module pixreg_chk #(
  parameter int WORD_W = 30,
  parameter int TS_W   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bunch_tick,
  input logic              train_stop,
  input logic              capture_active,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic [TS_W-1:0]   ts_cur
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R8
  AST_QUIET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_active |-> !rd_valid); // R8
  AST_EOD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_data[WORD_W-1] |=> !rd_valid && !capture_active); // R9
  AST_EOD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_data[WORD_W-1] |-> rd_data[WORD_W-3:0] == '0); // R9
  AST_TS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_active) |-> ts_cur == '0); // R5
  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    capture_active && $past(capture_active && bunch_tick && !train_stop)
    |-> ts_cur == TS_W'($past(ts_cur) + 1'b1)); // R5
endmodule

bind pixreg_hitbuf pixreg_chk #(.WORD_W(WORD_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rs_n), .bunch_tick(bunch_tick), .train_stop(train_stop),
  .capture_active(capture_active), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .ts_cur(ts_q)
);

// File: tb/pixreg_hitbuf_bench.sv
module pixreg_hitbuf_bench;
  localparam int NCOL = 4, NGRP = 7, GP = 6, PIX = 42, TS_W = 13, DEPTH = 16;
  localparam int W = 30;

  logic clk, rst_n, train_start, train_stop, bunch_tick, rd_ready;
  logic [NCOL*PIX-1:0] hit_v, mask_v;
  logic capture_active, rd_valid;
  logic [W-1:0] rd_data;

  int total, fails;
  bit finished;

  logic [21:0]     exq [NCOL][$];
  bit              mov [NCOL];
  logic [TS_W-1:0] mts;
  bit              mcap;

  pixreg_hitbuf u_pixreg_hitbuf (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_stop(train_stop),
    .bunch_tick(bunch_tick), .hit_i(hit_v), .mask_i(mask_v), .rd_ready(rd_ready),
    .capture_active(capture_active), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk_rec(input logic [TS_W-1:0] t, input int g, input logic [5:0] p);
    return {t, 3'(g), p};
  endfunction

  // one bunch; model follows R1, R2, R4, R5, R6, R7
  task automatic bunch(input logic [NCOL*PIX-1:0] h);
    @(negedge clk);
    hit_v = h; bunch_tick = 1'b1;
    if (mcap) begin
      for (int c = 0; c < NCOL; c++)
        for (int g = 0; g < NGRP; g++) begin
          logic [5:0] p;
          p = h[c*PIX + g*GP +: GP] & ~mask_v[c*PIX + g*GP +: GP];
          if (p != 0) begin
            if (exq[c].size() < DEPTH) exq[c].push_back(mk_rec(mts, g, p));
            else mov[c] = 1'b1;
          end
        end
      if (&mts) mcap = 1'b0;
      mts = mts + 1'b1;
    end
    @(negedge clk);
    bunch_tick = 1'b0; hit_v = '0;
    repeat (NGRP) @(negedge clk);
  endtask

  task automatic start_train();
    @(negedge clk); train_start = 1'b1;
    @(negedge clk); train_start = 1'b0;
    mcap = 1'b1; mts = '0;
    chk(capture_active == 1'b1, "R5 capture_active after start", 32'(capture_active), 1);
  endtask

  task automatic stop_train();
    @(negedge clk); train_stop = 1'b1;
    @(negedge clk); train_stop = 1'b0;
    mcap = 1'b0;
    chk(capture_active == 1'b0, "R6 capture_active after stop", 32'(capture_active), 0);
  endtask

  task automatic drain(input int rdy_pct, input bit poke, input string req);
    logic [W-1:0] exp_w [$];
    logic [W-1:0] got [$];
    logic [W-1:0] prev_d;
    bit prev_stall, done, any_ovf;
    int k;
    any_ovf = 1'b0;
    for (int c = 0; c < NCOL; c++) begin
      foreach (exq[c][i]) exp_w.push_back({1'b0, mov[c], 6'(c), exq[c][i]});
      any_ovf |= mov[c];
    end
    exp_w.push_back({1'b1, any_ovf, 28'b0});
    prev_stall = 1'b0; done = 1'b0; k = 0; prev_d = '0;
    while (!done && k < 20000) begin
      @(negedge clk);
      if (poke) train_start = (k == 5);
      if (poke && k == 6)
        chk(capture_active == 1'b0, "R10 start ignored in drain", 32'(capture_active), 0);
      if (prev_stall)
        chk(rd_valid && rd_data == prev_d, "R8 stalled word held", 32'(rd_data), 32'(prev_d));
      rd_ready = ($urandom % 100) < rdy_pct;
      if (capture_active)
        chk(!rd_valid, "R8 no readout during capture", 32'(rd_valid), 0);
      if (rd_valid && rd_ready) begin
        got.push_back(rd_data);
        if (rd_data[29]) done = 1'b1;
      end
      prev_stall = rd_valid && !rd_ready;
      prev_d = rd_data;
      k++;
    end
    @(negedge clk);
    rd_ready = 1'b0; train_start = 1'b0;
    chk(!rd_valid, "R9 valid low after end word", 32'(rd_valid), 0);
    chk(got.size() == exp_w.size(), {req, " word count"}, 32'(got.size()), 32'(exp_w.size()));
    for (int i = 0; i < exp_w.size(); i++) begin
      logic [W-1:0] a;
      a = (i < got.size()) ? got[i] : '0;
      chk(a == exp_w[i], req, 32'(a), 32'(exp_w[i]));
    end
    for (int c = 0; c < NCOL; c++) begin
      exq[c].delete();
      mov[c] = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [NCOL*PIX-1:0] h;
    void'($urandom(32'd4242));
    total = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0; train_start = 1'b0; train_stop = 1'b0; bunch_tick = 1'b0;
    rd_ready = 1'b0; hit_v = '0; mask_v = '0; mcap = 1'b0; mts = '0;
    for (int c = 0; c < NCOL; c++) mov[c] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_valid, "R11 rd_valid after reset", 32'(rd_valid), 0);
    chk(!capture_active, "R11 capture_active after reset", 32'(capture_active), 0);

    // directed train: masking, group order, stop
    mask_v = '0;
    mask_v[3] = 1'b1;                          // col0 pixel 3
    mask_v[PIX + 12 +: 6] = 6'h3f;             // col1 group 2
    start_train();
    h = '0;
    h[3] = 1'b1; h[31] = 1'b1; h[7] = 1'b1;    // col0: masked, group5, group1
    h[PIX + 12 +: 6] = 6'h3f; h[PIX + 41] = 1'b1;
    h[3*PIX +: PIX] = '1;                      // col3: every group
    bunch(h);
    bunch('0);
    h = '0; h[2*PIX] = 1'b1; h[3] = 1'b1;
    bunch(h);
    stop_train();
    h = '0; h[0] = 1'b1; h[2*PIX + 5] = 1'b1;
    bunch(h);                                  // after stop: dropped
    drain(100, 1'b0, "R1 R2 R3 R4 R6 directed");

    // random train with throttled readout and a start poke
    for (int i = 0; i < NCOL*PIX; i++) mask_v[i] = (($urandom % 8) == 0);
    start_train();
    for (int b = 0; b < 40; b++) begin
      h = '0;
      for (int c = 0; c < NCOL; c++)
        if (($urandom % 4) == 0) h[c*PIX + ($urandom % PIX)] = 1'b1;
      bunch(h);
    end
    stop_train();
    drain(70, 1'b1, "R2 R5 R8 R10 random");

    // overflow in column 1
    mask_v = '0;
    start_train();
    for (int b = 0; b < 20; b++) begin
      h = '0;
      h[PIX + (b % 6)] = 1'b1; h[PIX + 36 + (b % 6)] = 1'b1;
      h[2*PIX + 18] = (b < 3);
      bunch(h);
    end
    stop_train();
    drain(60, 1'b0, "R7 R9 overflow");

    // next train must start clean
    start_train();
    h = '0; h[PIX + 20] = 1'b1; h[10] = 1'b1;
    bunch(h);
    stop_train();
    drain(100, 1'b0, "R9 cleared buffers");

    // full timestamp range, then ticks after the wrap
    start_train();
    for (int b = 0; b < 8195; b++) begin
      h = '0;
      if (b >= 8189) h[2*PIX + (b % PIX)] = 1'b1;
      bunch(h);
    end
    chk(!capture_active, "R6 capture ends at wrap", 32'(capture_active), 0);
    drain(90, 1'b0, "R5 R6 wrap");

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule